// File: doc/BRIEF.md
# Message-Signalled Interrupt Doorbell Frame

This block is one memory-mapped interrupt frame that occupies a 4 KB register window. A peripheral raises an interrupt by writing a 32-bit word into the frame's doorbell register instead of driving a dedicated wire. The written word is an interrupt ID. If that ID lies inside the window of shared-peripheral interrupt IDs the frame owns, the frame pulses the matching output line for one cycle. Each output line feeds the interrupt controller.

The owned window is fixed by two build-time parameters, so the frame needs no programming before use. Two read-only info registers report the first owned ID and the number of owned IDs. Software uses them to find out which payloads are legal. A doorbell word outside the window is dropped. It raises no line and sets a sticky error flag, and a read of the status register clears that flag. A system with several frames must give each frame its own window, with no overlap, so that devices on different frames stay isolated.

Top module: `msi_doorbell_frame`

## Requirements
- R1: A read of offset 0x000 returns the first owned ID (`ID_FIRST`), and a read of offset 0x004 returns the owned ID count (`ID_TOTAL`). Read data appears on `rd_data` in the cycle after `rd_en`.
- R2: A write to the doorbell at offset 0x040 with a payload P, where ID_FIRST <= P < ID_FIRST+ID_TOTAL, drives `irq_pulse[P-ID_FIRST]` high for exactly the one cycle after the write. All other lines stay low.
- R3: A doorbell write whose payload lies outside the owned window raises no line. It sets `err_sticky`, which is also bit 0 of the status register at offset 0x010, from the cycle after the write onward.
- R4: A read of the status register returns the error flag in bit 0, with zeros above it, and clears the flag. If an out-of-window doorbell write lands in the same cycle as that read, the flag stays set.
- R5: Doorbell writes on consecutive cycles are each honoured, giving one pulse per write on consecutive cycles.
- R6: A read of the doorbell offset returns zero, and a read of any unmapped offset returns zero.
- R7: Writes to the info registers and the status register change nothing: later reads return the same values and the error flag is unchanged.
- R8: While `rst_n` is low, `irq_pulse`, `err_sticky` and `rd_data` are all zero.
- R9: A write to any offset other than exactly 0x040 raises no line and sets no error. This includes offsets that are not word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Byte offset of the write inside the frame |
| wr_data | input | 32 | Write data; for the doorbell, the interrupt ID |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 12 | Byte offset of the read inside the frame |
| rd_data | output | 32 | Read data, valid in the cycle after `rd_en` |
| irq_pulse | output | ID_TOTAL | One-cycle interrupt pulses, bit i for ID ID_FIRST+i |
| err_sticky | output | 1 | Sticky flag for dropped out-of-window doorbell writes |

## Verification
The hardest case to reach is the collision of a status read that clears the flag with a new out-of-window doorbell write in the same cycle. The bench first sets the flag with a bad write. It then drives the status read and a second bad write on the same clock edge, and checks that the read reports the old flag and the flag stays set. Window edges are covered by writing IDs one below the window, the first and last owned IDs, and IDs one above the window and at the top of the 32-bit range. A burst of doorbell writes on consecutive cycles shows that no pulse is merged or lost.

// File: rtl/msi_doorbell_frame.sv
module msi_doorbell_frame #(
  parameter int unsigned ID_FIRST = 64,
  parameter int unsigned ID_TOTAL = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [11:0]         wr_addr,
  input  logic [31:0]         wr_data,
  input  logic                rd_en,
  input  logic [11:0]         rd_addr,
  output logic [31:0]         rd_data,
  output logic [ID_TOTAL-1:0] irq_pulse,
  output logic                err_sticky
);

  localparam logic [11:0] OFS_FIRST  = 12'h000;
  localparam logic [11:0] OFS_TOTAL  = 12'h004;
  localparam logic [11:0] OFS_STATUS = 12'h010;
  localparam logic [11:0] OFS_BELL   = 12'h040;
  localparam logic [32:0] WIN_LO     = 33'(ID_FIRST);
  localparam logic [32:0] WIN_HI     = 33'(ID_FIRST) + 33'(ID_TOTAL);

  logic                bell_hit;
  logic                in_win;
  logic [31:0]         slot;
  logic                status_rd;
  logic [ID_TOTAL-1:0] fire;
  logic [31:0]         rd_next;

  assign bell_hit  = wr_en && (wr_addr == OFS_BELL);
  assign in_win    = ({1'b0, wr_data} >= WIN_LO) && ({1'b0, wr_data} < WIN_HI);
  assign slot      = wr_data - 32'(ID_FIRST);
  assign status_rd = rd_en && (rd_addr == OFS_STATUS);

  for (genvar i = 0; i < ID_TOTAL; i++) begin : g_line
    assign fire[i] = bell_hit && in_win && (slot == 32'(i));
  end

  always_comb begin
    rd_next = '0;
    if (rd_en) begin
      case (rd_addr)
        OFS_FIRST:  rd_next = 32'(ID_FIRST);
        OFS_TOTAL:  rd_next = 32'(ID_TOTAL);
        OFS_STATUS: rd_next = {31'b0, err_sticky};
        default:    rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pulse  <= '0;
      err_sticky <= 1'b0;
      rd_data    <= '0;
    end else begin
      irq_pulse  <= fire;
      err_sticky <= (bell_hit && !in_win) || (err_sticky && !status_rd);
      rd_data    <= rd_next;
    end
  end

endmodule

// File: rtl/msi_doorbell_frame_chk.sv
module msi_doorbell_frame_chk #(
  parameter int unsigned ID_FIRST = 64,
  parameter int unsigned ID_TOTAL = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic [11:0]         wr_addr,
  input logic [31:0]         wr_data,
  input logic                rd_en,
  input logic [11:0]         rd_addr,
  input logic [31:0]         rd_data,
  input logic [ID_TOTAL-1:0] irq_pulse,
  input logic                err_sticky
);

  logic bell, good;
  assign bell = wr_en && (wr_addr == 12'h040);
  assign good = ({1'b0, wr_data} >= 33'(ID_FIRST)) &&
                ({1'b0, wr_data} < 33'(ID_FIRST) + 33'(ID_TOTAL));

  assert_single_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_pulse));

  assert_pulse_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bell && good) |=> irq_pulse == (ID_TOTAL'(1) << ($past(wr_data) - 32'(ID_FIRST))));

  assert_drop_bad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bell && !good) |=> (irq_pulse == '0) && err_sticky);

  assert_no_stray_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bell |=> irq_pulse == '0);

  assert_status_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 12'h010 && !(bell && !good)) |=> !err_sticky);

  assert_status_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 12'h010) |=> rd_data == {31'b0, $past(err_sticky)});

  assert_bell_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 12'h040) |=> rd_data == '0);

  assert_info_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 12'h000) |=> rd_data == 32'(ID_FIRST));

  assert_info_total_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 12'h004) |=> rd_data == 32'(ID_TOTAL));

endmodule

bind msi_doorbell_frame msi_doorbell_frame_chk #(
  .ID_FIRST(ID_FIRST), .ID_TOTAL(ID_TOTAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_pulse(irq_pulse),
  .err_sticky(err_sticky)
);

// File: tb/test_msi_doorbell_frame.sv
module test_msi_doorbell_frame;
  localparam int unsigned FIRST = 64;
  localparam int unsigned TOTAL = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [11:0]       wr_addr = '0;
  logic [31:0]       wr_data = '0;
  logic              rd_en = 1'b0;
  logic [11:0]       rd_addr = '0;
  logic [31:0]       rd_data;
  logic [TOTAL-1:0]  irq_pulse;
  logic              err_sticky;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  msi_doorbell_frame #(.ID_FIRST(FIRST), .ID_TOTAL(TOTAL)) i_msi_doorbell_frame (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_pulse(irq_pulse),
    .err_sticky(err_sticky)
  );

  // {addr[12], payload[32], expected pulse[16], expected error[1]}
  localparam int NV = 8;
  localparam logic [60:0] VEC [NV] = '{
    {12'h040, 32'd64,         16'h0001, 1'b0},
    {12'h040, 32'd79,         16'h8000, 1'b0},
    {12'h040, 32'd70,         16'h0040, 1'b0},
    {12'h040, 32'd63,         16'h0000, 1'b1},
    {12'h040, 32'd80,         16'h0000, 1'b1},
    {12'h040, 32'hFFFF_FFFF,  16'h0000, 1'b1},
    {12'h044, 32'd70,         16'h0000, 1'b0},
    {12'h041, 32'd70,         16'h0000, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_reg(input logic [11:0] a);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 pulse in reset", 32'(irq_pulse), 32'h0);
    chk("R8 error in reset", 32'(err_sticky), 32'h0);
    chk("R8 rd_data in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    rd_reg(12'h000); chk("R1 first id", rd_data, 32'(FIRST));
    rd_reg(12'h004); chk("R1 id count", rd_data, 32'(TOTAL));

    for (int v = 0; v < NV; v++) begin
      wr_reg(VEC[v][60:49], VEC[v][48:17]);
      chk($sformatf("R2/R3/R9 pulse vec%0d", v), 32'(irq_pulse), 32'(VEC[v][16:1]));
      chk($sformatf("R3/R9 error vec%0d", v), 32'(err_sticky), 32'(VEC[v][0]));
      rd_reg(12'h010);
      chk($sformatf("R2 pulse one cycle vec%0d", v), 32'(irq_pulse), 32'h0);
      chk($sformatf("R4 status read vec%0d", v), rd_data, {31'b0, VEC[v][0]});
      chk($sformatf("R4 status cleared vec%0d", v), 32'(err_sticky), 32'h0);
    end

    wr_en = 1'b1; wr_addr = 12'h040; wr_data = 32'd65;
    @(negedge clk); wr_data = 32'd66;
    chk("R5 burst 1", 32'(irq_pulse), 32'h0002);
    @(negedge clk); wr_data = 32'd67;
    chk("R5 burst 2", 32'(irq_pulse), 32'h0004);
    @(negedge clk); wr_en = 1'b0;
    chk("R5 burst 3", 32'(irq_pulse), 32'h0008);
    @(negedge clk);
    chk("R5 burst end", 32'(irq_pulse), 32'h0);

    rd_reg(12'h040); chk("R6 doorbell reads zero", rd_data, 32'h0);
    rd_reg(12'h800); chk("R6 unmapped reads zero", rd_data, 32'h0);

    wr_reg(12'h000, 32'h1234);
    wr_reg(12'h004, 32'h5);
    wr_reg(12'h010, 32'h1);
    chk("R7 status write no error", 32'(err_sticky), 32'h0);
    rd_reg(12'h000); chk("R7 first id unchanged", rd_data, 32'(FIRST));
    rd_reg(12'h004); chk("R7 count unchanged", rd_data, 32'(TOTAL));

    wr_reg(12'h040, 32'd200);
    chk("R3 error set", 32'(err_sticky), 32'h1);
    wr_en = 1'b1; wr_addr = 12'h040; wr_data = 32'd10;
    rd_en = 1'b1; rd_addr = 12'h010;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R4 collision read value", rd_data, 32'h1);
    chk("R4 collision flag kept", 32'(err_sticky), 32'h1);
    rd_reg(12'h010);
    chk("R4 final read value", rd_data, 32'h1);
    chk("R4 final clear", 32'(err_sticky), 32'h0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule